// File: doc/BRIEF.md
# VSYNC Field Detection Filter

This block re-times a vertical sync pulse against a clean horizontal sync. On every clock it tracks where the current pixel sits inside the line, measured from the last HSYNC rising edge. When a VSYNC rising edge arrives, the block looks at where that edge falls in the line and decides whether the frame is field 0 or field 1. It then emits a regenerated VSYNC in the following line, at a fixed place. For field 0 that place is the HSYNC leading edge. For field 1 it is the middle of the line.

The line length is measured continuously as the distance between consecutive HSYNC rising edges. The quadrant boundaries come from that length by a shift. A user-supplied separator threshold moves the start of the first quadrant. The output pulse lasts a whole number of lines, equal to the number of HSYNC edges seen while the input VSYNC was high. A bypass control hands the raw input straight to the output.

Top module: `vsyncFieldFilter`

## Requirements
- R1: Let L be the cycle count between the two most recent HSYNC rising edges. The HSYNC rising-edge cycle is position 0. Let T be the threshold and q = L>>2. A VSYNC rising edge at position p has relative offset r = p−T when p ≥ T, and r = p+L−T otherwise. The frame is field 1 when q ≤ r < 3q, and field 0 otherwise.
- R2: For field 0, the regenerated VSYNC goes high in the cycle after the first HSYNC rising edge that follows the detected VSYNC edge, with fieldOut 0.
- R3: For field 1, the regenerated VSYNC goes high in the cycle after position L>>1 of the line that follows the detected edge, with fieldOut 1.
- R4: Let W be the number of HSYNC rising edges that occur while VSYNC is high, after its rising cycle, with W taken as at least 1. The regenerated pulse falls at the same anchor (HSYNC edge or mid-line) W lines after it rose, so it stays high for W·L cycles.
- R5: With the filter enabled, fieldOut changes only in the cycle in which vsyncOut rises. It keeps its old value while a new detection is pending.
- R6: With filtEn low, vsyncOut equals vsyncIn in the same cycle and fieldOut is 0.
- R7: A VSYNC rising edge that arrives while a pulse is pending or being emitted is ignored. It neither starts a second pulse nor changes the width or field of the current one.
- R8: While reset is asserted, vsyncOut and fieldOut are 0 with filtEn high, and all counters are cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel-rate clock |
| rstN | input | 1 | Asynchronous active-low reset |
| filtEn | input | 1 | 1 selects the regenerated VSYNC, 0 passes the input through |
| hsyncIn | input | 1 | Filtered HSYNC, active high |
| vsyncIn | input | 1 | Raw VSYNC, active high |
| sepThresh | input | CNT_W | Offset from the HSYNC edge to the start of the first quadrant, in clocks (less than the line length) |
| vsyncOut | output | 1 | Regenerated or bypassed VSYNC |
| fieldOut | output | 1 | Field flag of the current frame |

## Verification
A wrong line-length or position count moves the quadrant boundaries. The first VSYNC edge placed one clock either side of a boundary then flips fieldOut, and the output rise moves between the HSYNC edge and mid-line one line later. A width counter that is off by one shows as a pulse one line too long or too short at the falling edge. A sequencer that accepts a late VSYNC edge shows as a second pulse within a few lines. The reference model is compared with the outputs on every clock, so each of these faults is reported in the first cycle the output diverges.

// File: rtl/vff_pkg.sv
package vff_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_PEND,
    ST_MID,
    ST_ACTIVE
  } vffState_t;

  // control -> datapath
  typedef struct packed {
    logic startMeas;
    logic setOut;
    logic clrOut;
    logic bumpAnchor;
  } vffStrobe_t;

  // datapath -> control
  typedef struct packed {
    logic hsRise;
    logic vsRise;
    logic midHit;
    logic pendField;
    logic reachWidth;
  } vffStatus_t;

endpackage

// File: rtl/vff_datapath.sv
module vff_datapath
  import vff_pkg::*;
#(
  parameter int CNT_W  = 12,
  parameter int LINE_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             hsyncIn,
  input  logic             vsyncIn,
  input  logic [CNT_W-1:0] sepThresh,
  input  vffStrobe_t       strobe,
  output vffStatus_t       status,
  output logic             vsyncReg,
  output logic             fieldReg
);
  localparam int REL_W = CNT_W + 2;
  localparam logic [CNT_W-1:0]  POS_MAX  = '1;
  localparam logic [LINE_W-1:0] LINE_MAX = '1;
  localparam logic [LINE_W:0]   ANC_MAX  = '1;

  logic hsPrev, vsPrev, hsRise, vsRise, vsFall;
  logic [CNT_W-1:0] pos, lineLen, curPos, halfLen;
  logic [REL_W-1:0] curW, lenW, thrW, relW, qW, q3W;
  logic inMid, midHit;
  logic [LINE_W-1:0] wCnt, wEff;
  logic measOn, measDone, pendField;
  logic [LINE_W:0] anchorCnt, anchorNext;

  // position in line and quadrant classification
  always_comb begin
    hsRise = hsyncIn & ~hsPrev;
    vsRise = vsyncIn & ~vsPrev;
    vsFall = ~vsyncIn & vsPrev;
    if (hsRise)              curPos = '0;
    else if (pos == POS_MAX) curPos = pos;
    else                     curPos = pos + 1'b1;
    halfLen = lineLen >> 1;
    curW = REL_W'(curPos);
    lenW = REL_W'(lineLen);
    thrW = REL_W'(sepThresh);
    qW   = REL_W'(lineLen >> 2);
    q3W  = qW + (qW << 1);
    relW = (curW >= thrW) ? (curW - thrW) : (curW + lenW - thrW);
    inMid  = (relW >= qW) && (relW < q3W);
    midHit = ~hsRise && (halfLen != '0) && (curPos == halfLen);
    wEff = (wCnt == '0) ? LINE_W'(1) : wCnt;
    anchorNext = (anchorCnt == ANC_MAX) ? anchorCnt : anchorCnt + 1'b1;
  end

  always_comb begin
    status.hsRise     = hsRise;
    status.vsRise     = vsRise;
    status.midHit     = midHit;
    status.pendField  = pendField;
    status.reachWidth = measDone && (anchorNext >= {1'b0, wEff});
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hsPrev    <= 1'b0;
      vsPrev    <= 1'b0;
      pos       <= '0;
      lineLen   <= '0;
      pendField <= 1'b0;
      wCnt      <= '0;
      measOn    <= 1'b0;
      measDone  <= 1'b0;
      anchorCnt <= '0;
      vsyncReg  <= 1'b0;
      fieldReg  <= 1'b0;
    end else begin
      hsPrev <= hsyncIn;
      vsPrev <= vsyncIn;
      pos    <= curPos;
      if (hsRise) lineLen <= pos + 1'b1;

      // input pulse width in lines
      if (strobe.startMeas) begin
        pendField <= inMid;
        wCnt      <= '0;
        measOn    <= 1'b1;
        measDone  <= 1'b0;
      end else if (measOn) begin
        if (vsFall) begin
          measOn   <= 1'b0;
          measDone <= 1'b1;
        end else if (hsRise && vsyncIn && wCnt != LINE_MAX) begin
          wCnt <= wCnt + 1'b1;
        end
      end

      // regenerated output
      if (strobe.setOut) begin
        vsyncReg  <= 1'b1;
        fieldReg  <= pendField;
        anchorCnt <= '0;
      end else if (strobe.clrOut) begin
        vsyncReg <= 1'b0;
      end else if (strobe.bumpAnchor) begin
        anchorCnt <= anchorNext;
      end
    end
  end

endmodule

// File: rtl/vff_control.sv
module vff_control
  import vff_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  vffStatus_t status,
  output vffStrobe_t strobe
);
  vffState_t state, nxt;
  logic anchor;

  always_comb begin
    strobe = '0;
    nxt    = state;
    anchor = status.pendField ? status.midHit : status.hsRise;
    unique case (state)
      ST_IDLE: if (status.vsRise) begin
        strobe.startMeas = 1'b1;
        nxt = ST_PEND;
      end
      ST_PEND: if (status.hsRise) begin
        if (status.pendField) begin
          nxt = ST_MID;
        end else begin
          strobe.setOut = 1'b1;
          nxt = ST_ACTIVE;
        end
      end
      ST_MID: if (status.midHit) begin
        strobe.setOut = 1'b1;
        nxt = ST_ACTIVE;
      end
      ST_ACTIVE: if (anchor) begin
        if (status.reachWidth) begin
          strobe.clrOut = 1'b1;
          nxt = ST_IDLE;
        end else begin
          strobe.bumpAnchor = 1'b1;
        end
      end
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nxt;
  end

endmodule

// File: rtl/vsyncFieldFilter.sv
module vsyncFieldFilter
  import vff_pkg::*;
#(
  parameter int CNT_W  = 12,
  parameter int LINE_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             filtEn,
  input  logic             hsyncIn,
  input  logic             vsyncIn,
  input  logic [CNT_W-1:0] sepThresh,
  output logic             vsyncOut,
  output logic             fieldOut
);
  vffStrobe_t strobe;
  vffStatus_t status;
  logic vsyncReg, fieldReg;

  vff_datapath #(.CNT_W(CNT_W), .LINE_W(LINE_W)) u_dp (
    .clk(clk), .rstN(rstN), .hsyncIn(hsyncIn), .vsyncIn(vsyncIn),
    .sepThresh(sepThresh), .strobe(strobe), .status(status),
    .vsyncReg(vsyncReg), .fieldReg(fieldReg)
  );

  vff_control u_ctl (
    .clk(clk), .rstN(rstN), .status(status), .strobe(strobe)
  );

  assign vsyncOut = filtEn ? vsyncReg : vsyncIn;
  assign fieldOut = filtEn ? fieldReg : 1'b0;

endmodule

// File: rtl/vff_checker.sv
module vff_checker (
  input logic clk,
  input logic rstN,
  input logic filtEn,
  input logic hsyncIn,
  input logic vsyncOut,
  input logic fieldOut
);
  logic hsQ, hsRiseQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hsQ     <= 1'b0;
      hsRiseQ <= 1'b0;
    end else begin
      hsQ     <= hsyncIn;
      hsRiseQ <= hsyncIn & ~hsQ;
    end
  end

  p_field_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    (filtEn && $past(filtEn) && !$rose(vsyncOut)) |-> $stable(fieldOut));

  p_f0_rise_r2: assert property (@(posedge clk) disable iff (!rstN)
    (filtEn && $past(filtEn) && $rose(vsyncOut) && !fieldOut) |-> hsRiseQ);

  p_f1_rise_r3: assert property (@(posedge clk) disable iff (!rstN)
    (filtEn && $past(filtEn) && $rose(vsyncOut) && fieldOut) |-> !hsRiseQ);

  p_f0_fall_r4: assert property (@(posedge clk) disable iff (!rstN)
    (filtEn && $past(filtEn) && $fell(vsyncOut) && !fieldOut) |-> hsRiseQ);

  p_min_len_r4: assert property (@(posedge clk) disable iff (!rstN)
    (filtEn && $past(filtEn) && $rose(vsyncOut)) |=> (!filtEn || vsyncOut));

endmodule

bind vsyncFieldFilter vff_checker u_chk (
  .clk(clk), .rstN(rstN), .filtEn(filtEn), .hsyncIn(hsyncIn),
  .vsyncOut(vsyncOut), .fieldOut(fieldOut)
);

// File: tb/vsyncFieldFilter_tb.sv
`timescale 1ns/1ps
module vsyncFieldFilter_tb;
  localparam int CNT_W = 12;
  localparam int LINE_W = 8;
  localparam int LL = 64;
  localparam int HS_W = 6;
  localparam int THR = 4;

  logic clk = 1'b0, rstN = 1'b0, filtEn = 1'b1, hsyncIn = 1'b0, vsyncIn = 1'b0;
  logic [CNT_W-1:0] sepThresh = CNT_W'(THR);
  logic vsyncOut, fieldOut;

  int errors = 0, checks = 0;
  int hPhase = LL - 1;
  string curReq = "R8";
  int riseCount, risePhase, highCnt, prevVo = 0;

  vsyncFieldFilter #(.CNT_W(CNT_W), .LINE_W(LINE_W)) u_dut (
    .clk(clk), .rstN(rstN), .filtEn(filtEn), .hsyncIn(hsyncIn),
    .vsyncIn(vsyncIn), .sepThresh(sepThresh),
    .vsyncOut(vsyncOut), .fieldOut(fieldOut)
  );

  always #2 clk = ~clk;

  // behavioural reference model
  int mPrevH, mPrevV, mPos, mLen, mState, mPf, mW, mMeas, mDone, mAcnt, mVs, mField;
  always @(posedge clk) begin : refModel
    int hr, vr, vf, cur, rel, q, half, f1, mid, reach, weff, anc;
    if (!rstN) begin
      mPrevH = 0; mPrevV = 0; mPos = 0; mLen = 0; mState = 0; mPf = 0;
      mW = 0; mMeas = 0; mDone = 0; mAcnt = 0; mVs = 0; mField = 0;
    end else begin
      hr = (hsyncIn && mPrevH == 0) ? 1 : 0;
      vr = (vsyncIn && mPrevV == 0) ? 1 : 0;
      vf = (!vsyncIn && mPrevV == 1) ? 1 : 0;
      cur = hr ? 0 : ((mPos == 4095) ? mPos : mPos + 1);
      rel = (cur >= THR) ? cur - THR : cur + mLen - THR;
      q = mLen / 4;
      f1 = (rel >= q && rel < 3 * q) ? 1 : 0;
      half = mLen / 2;
      mid = (hr == 0 && half != 0 && cur == half) ? 1 : 0;
      weff = (mW == 0) ? 1 : mW;
      reach = (mDone == 1 && mAcnt + 1 >= weff) ? 1 : 0;
      if (mState == 0 && vr == 1) begin
        mPf = f1; mW = 0; mMeas = 1; mDone = 0; mState = 1;
      end else begin
        if (mMeas == 1 && vf == 1) begin mMeas = 0; mDone = 1; end
        else if (mMeas == 1 && hr == 1 && vsyncIn && mW < 255) mW = mW + 1;
        case (mState)
          1: if (hr == 1) begin
               if (mPf == 1) mState = 2;
               else begin mVs = 1; mField = 0; mAcnt = 0; mState = 3; end
             end
          2: if (mid == 1) begin mVs = 1; mField = 1; mAcnt = 0; mState = 3; end
          3: begin
               anc = (mPf == 1) ? mid : hr;
               if (anc == 1) begin
                 if (reach == 1) begin mVs = 0; mState = 0; end
                 else if (mAcnt < 511) mAcnt = mAcnt + 1;
               end
             end
          default: ;
        endcase
      end
      if (hr == 1) mLen = (mPos + 1) % 4096;
      mPos = cur;
      mPrevH = hsyncIn ? 1 : 0;
      mPrevV = vsyncIn ? 1 : 0;
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic compare();
    check({curReq, "_vsync_model"}, int'(vsyncOut), filtEn ? mVs : int'(vsyncIn));
    check({curReq, "_field_model"}, int'(fieldOut), filtEn ? mField : 0);
    if (filtEn && vsyncOut && prevVo == 0) begin riseCount++; risePhase = hPhase; end
    if (filtEn && vsyncOut) highCnt++;
    prevVo = vsyncOut ? 1 : 0;
  endtask

  task automatic step();
    @(negedge clk);
    compare();
    hPhase = (hPhase + 1) % LL;
    hsyncIn = (hPhase < HS_W);
  endtask

  task automatic waitPhase(input int p);
    do step(); while (hPhase != p);
  endtask

  task automatic scen(input int p, input int lenCyc, input int expF, input int expHigh, input string req);
    int preF;
    curReq = req; riseCount = 0; highCnt = 0; risePhase = -1;
    preF = fieldOut ? 1 : 0;
    waitPhase(p);
    vsyncIn = 1'b1;
    repeat (lenCyc) step();
    vsyncIn = 1'b0;
    if (riseCount == 0) check({"R5_hold_in_", req}, int'(fieldOut), preF);
    repeat (6 * LL) step();
    check({req, "_field"}, int'(fieldOut), expF);
    check({req, "_rise_phase"}, risePhase, expF ? LL / 2 : 0);
    check({req, "_high_cycles"}, highCnt, expHigh);
    check({req, "_pulse_count"}, riseCount, 1);
  endtask

  initial begin
    repeat (3) step();
    check("R8_reset_vsync", int'(vsyncOut), 0);
    check("R8_reset_field", int'(fieldOut), 0);
    rstN = 1'b1;
    repeat (3 * LL) step();

    scen(10, 3 * LL, 0, 3 * LL, "R2");
    scen(30, 3 * LL, 1, 3 * LL, "R3");
    scen(10, 5, 0, LL, "R4");          // follows a field-1 frame: R5 hold check
    scen(10, 60, 0, LL, "R4");
    scen(10, 130, 0, 2 * LL, "R4");
    scen(19, 5, 0, LL, "R1");
    scen(20, 5, 1, LL, "R1");
    scen(51, 5, 1, LL, "R1");
    scen(52, 5, 0, LL, "R1");
    scen(2, 5, 0, LL, "R1");

    // R7: extra edges while pending and while active
    curReq = "R7"; riseCount = 0; highCnt = 0; risePhase = -1;
    waitPhase(10); vsyncIn = 1'b1; repeat (5) step(); vsyncIn = 1'b0;
    repeat (20) step();
    vsyncIn = 1'b1; repeat (5) step(); vsyncIn = 1'b0;
    repeat (44) step();
    vsyncIn = 1'b1; repeat (5) step(); vsyncIn = 1'b0;
    repeat (6 * LL) step();
    check("R7_field", int'(fieldOut), 0);
    check("R7_pulse_count", riseCount, 1);
    check("R7_high_cycles", highCnt, LL);

    // R6: bypass
    curReq = "R6";
    filtEn = 1'b0;
    waitPhase(30); vsyncIn = 1'b1; #1;
    check("R6_follow_high", int'(vsyncOut), 1);
    check("R6_field_zero", int'(fieldOut), 0);
    repeat (10) step();
    vsyncIn = 1'b0; #1;
    check("R6_follow_low", int'(vsyncOut), 0);
    repeat (6 * LL) step();
    filtEn = 1'b1;
    repeat (LL) step();

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule